// File: doc/BRIEF.md
# Multiply Unit with High/Low Result Registers

This block is the integer multiply unit of a processor. A caller issues one of four commands: a signed multiply, an unsigned multiply, a read of the high result register or a read of the low result register. A multiply takes two W-bit operands (W = 32 by default). It runs on a sequential radix-2 recoded (Booth) engine, and the finished 2W-bit product goes into two dedicated registers. The high half lands in the high register and the low half in the low register. The read commands return one of those registers on a result bus for one cycle.

The unit raises no exception when a product does not fit in W bits. Instead it reports a status bit, fits_n, that says whether the last completed product can be represented in W bits under the rule for its own signedness. While a multiply runs, busy is high and no command is taken. The caller holds its command on the inputs, and the command is accepted in the first cycle busy is low.

Top module: `mulhl_unit`

## Requirements
- R1: Command code 2'b00 is a signed multiply. When it completes, {hi, lo} holds the 2W-bit two's-complement product of cmd_a and cmd_b.
- R2: Command code 2'b01 is an unsigned multiply. When it completes, {hi, lo} holds the 2W-bit unsigned product of cmd_a and cmd_b.
- R3: Command code 2'b10 reads the high register. In the cycle after acceptance, rd_valid is high for exactly one cycle and rd_data equals hi.
- R4: Command code 2'b11 reads the low register. In the cycle after acceptance, rd_valid is high for exactly one cycle and rd_data equals lo.
- R5: A command is accepted on a clock edge where cmd_valid is high and busy is low. After a multiply is accepted, busy is high for exactly W+2 cycles. A command presented during that time is held off and takes effect only after busy falls.
- R6: A read command presented while a multiply runs returns the result of that multiply, not the earlier value.
- R7: After an unsigned multiply completes, fits_n is 1 exactly when hi is all zeros.
- R8: After a signed multiply completes, fits_n is 1 exactly when every bit of hi equals bit W-1 of lo.
- R9: hi, lo and fits_n change only when a multiply completes. Read commands leave them unchanged.
- R10: Reset (rst_n low at a clock edge) clears hi and lo to zero, sets fits_n to 1 and clears busy and rd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is presented |
| cmd_op | input | 2 | 00 signed multiply, 01 unsigned multiply, 10 read high, 11 read low |
| cmd_a | input | W | Multiplicand |
| cmd_b | input | W | Multiplier |
| busy | output | 1 | A multiply is in progress; no command is accepted |
| rd_valid | output | 1 | rd_data carries a read result this cycle |
| rd_data | output | W | Read result |
| fits_n | output | 1 | The last completed product fits in W bits |

## Verification
Two situations are hardest to reach from the ports. The first is a command that arrives while a multiply is still in flight. The bench presents a second multiply, and then a read, immediately after a multiply has been accepted. It holds each one until busy drops, then checks that the held read returns the new product and that the held multiply replaces the first result. The second is the fit status at its boundaries. The bench therefore uses operand pairs whose products sit just inside and just outside the W-bit range in each signedness, including the most negative value squared. It then mixes these with random signed and unsigned commands that are checked against a 2W-bit model.

// File: rtl/mulhl_pkg.sv
// Shared command encoding for the multiply unit.
package mulhl_pkg;
    typedef enum logic [1:0] {
        OP_MUL_S = 2'b00,
        OP_MUL_U = 2'b01,
        OP_RD_HI = 2'b10,
        OP_RD_LO = 2'b11
    } mulhl_op_e;
endpackage

// File: rtl/mulhl_booth_core.sv
// Sequential radix-2 recoded multiplier.
// Operands are widened by one bit (sign or zero), so one engine serves both
// signedness modes. Takes W+1 steps after start, then raises done for one
// cycle. Assumes start is only given while idle.
module mulhl_booth_core #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           sgn,
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    output logic           done,
    output logic [2*W-1:0] product
);
    localparam int XW    = W + 1;
    localparam int AW    = W + 2;
    localparam int CNT_W = $clog2(W + 2);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W);

    typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} st_e;

    st_e              st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [AW-1:0]    acc_q;
    logic [XW-1:0]    mq_q;
    logic             qm1_q;
    logic [AW-1:0]    mcand_q;
    logic [AW-1:0]    sum;

    // Add or subtract the multiplicand as the recoded bit pair asks.
    always_comb begin
        case ({mq_q[0], qm1_q})
            2'b10:   sum = acc_q - mcand_q;
            2'b01:   sum = acc_q + mcand_q;
            default: sum = acc_q;
        endcase
    end

    // Sequencer and datapath: load, step with arithmetic shift, signal done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= S_IDLE;
            cnt_q   <= '0;
            acc_q   <= '0;
            mq_q    <= '0;
            qm1_q   <= 1'b0;
            mcand_q <= '0;
        end else begin
            case (st_q)
                S_IDLE: if (start) begin
                    st_q    <= S_RUN;
                    cnt_q   <= '0;
                    acc_q   <= '0;
                    qm1_q   <= 1'b0;
                    mq_q    <= {sgn & op_b[W-1], op_b};
                    mcand_q <= {{2{sgn & op_a[W-1]}}, op_a};
                end
                S_RUN: begin
                    acc_q <= {sum[AW-1], sum[AW-1:1]};
                    mq_q  <= {sum[0], mq_q[XW-1:1]};
                    qm1_q <= mq_q[0];
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST) st_q <= S_DONE;
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign done    = (st_q == S_DONE);
    assign product = {acc_q[W-2:0], mq_q};

    // done lasts exactly one cycle.
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // The step counter never passes the last step.
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_RUN) |-> (cnt_q <= LAST));
endmodule

// File: rtl/mulhl_fit_check.sv
// Decides whether a 2W-bit product can be represented in W bits.
// Unsigned: the high half is zero. Signed: the high half repeats the low sign bit.
module mulhl_fit_check #(
    parameter int W = 32
) (
    input  logic         sgn,
    input  logic [W-1:0] hi,
    input  logic [W-1:0] lo,
    output logic         fits
);
    // Pick the rule for the product's signedness.
    always_comb begin
        if (sgn) fits = (hi == {W{lo[W-1]}});
        else     fits = (hi == '0);
    end
endmodule

// File: rtl/mulhl_unit.sv
// Multiply unit with dedicated high/low result registers.
// Decodes commands, runs multiplies on the sequential core, holds the result
// and fit status, and serves register reads. Assumes the caller holds a
// command on the inputs until an edge where busy is low.
module mulhl_unit #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_valid,
    input  logic [1:0]   cmd_op,
    input  logic [W-1:0] cmd_a,
    input  logic [W-1:0] cmd_b,
    output logic         busy,
    output logic         rd_valid,
    output logic [W-1:0] rd_data,
    output logic         fits_n
);
    import mulhl_pkg::*;

    mulhl_op_e      op;
    logic           accept, is_mul, core_done, fit_new;
    logic [2*W-1:0] core_prod;
    logic           busy_q, sgn_q, fits_q, rd_valid_q;
    logic [W-1:0]   hi_q, lo_q, rd_data_q;

    assign op     = mulhl_op_e'(cmd_op);
    assign accept = cmd_valid && !busy_q;
    assign is_mul = (op == OP_MUL_S) || (op == OP_MUL_U);

    mulhl_booth_core #(.W(W)) core_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (accept && is_mul),
        .sgn     (op == OP_MUL_S),
        .op_a    (cmd_a),
        .op_b    (cmd_b),
        .done    (core_done),
        .product (core_prod)
    );

    mulhl_fit_check #(.W(W)) fit_i (
        .sgn  (sgn_q),
        .hi   (core_prod[2*W-1:W]),
        .lo   (core_prod[W-1:0]),
        .fits (fit_new)
    );

    // Busy interlock and signedness of the multiply in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            sgn_q  <= 1'b0;
        end else if (accept && is_mul) begin
            busy_q <= 1'b1;
            sgn_q  <= (op == OP_MUL_S);
        end else if (core_done) begin
            busy_q <= 1'b0;
        end
    end

    // Result registers and fit status, written when a multiply completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q   <= '0;
            lo_q   <= '0;
            fits_q <= 1'b1;
        end else if (core_done) begin
            hi_q   <= core_prod[2*W-1:W];
            lo_q   <= core_prod[W-1:0];
            fits_q <= fit_new;
        end
    end

    // Read port: one-cycle result for an accepted read command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= accept && !is_mul;
            if (accept && !is_mul)
                rd_data_q <= (op == OP_RD_HI) ? hi_q : lo_q;
        end
    end

    assign busy     = busy_q;
    assign rd_valid = rd_valid_q;
    assign rd_data  = rd_data_q;
    assign fits_n   = fits_q;

    // An accepted multiply raises busy on the next cycle.
    assert_busy_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && is_mul) |=> busy);
    // No read completes in the cycle after a busy cycle.
    assert_no_read_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !rd_valid);
    // Result registers hold unless the core finishes.
    assert_hilo_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !core_done |=> ($stable(hi_q) && $stable(lo_q) && $stable(fits_n)));
    // Unsigned fit status agrees with the stored high half.
    assert_fit_unsigned_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !sgn_q && fits_n) |-> (hi_q == '0));
    // Signed fit status agrees with the stored halves.
    assert_fit_signed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && sgn_q && fits_n) |-> (hi_q == {W{lo_q[W-1]}}));
    // A read result arrives exactly one cycle after acceptance.
    assert_read_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(cmd_valid && !busy));
endmodule

// File: tb/mulhl_unit_tb_top.sv
module mulhl_unit_tb_top;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic [1:0]   cmd_op = 2'b00;
    logic [W-1:0] cmd_a = '0;
    logic [W-1:0] cmd_b = '0;
    logic         busy, rd_valid, fits_n;
    logic [W-1:0] rd_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    logic [W-1:0] exp_q[$];
    string        tag_q[$];

    always #2.5 clk = ~clk;

    mulhl_unit #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_a(cmd_a), .cmd_b(cmd_b), .busy(busy), .rd_valid(rd_valid),
        .rd_data(rd_data), .fits_n(fits_n)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: compare each read result against the scoreboard (R3, R4).
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3/R4 unexpected read", 64'(rd_data), 64'(0));
            end else begin
                logic [W-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(rd_data == e, t, 64'(rd_data), 64'(e));
            end
        end
    end

    // Present a command, hold it until accepted, release at the next negedge.
    task automatic issue(input logic [1:0] op, input logic [W-1:0] a,
                         input logic [W-1:0] b);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_a = a; cmd_b = b;
        while (busy) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    function automatic logic [2*W-1:0] model(input bit sgn, input logic [W-1:0] a,
                                             input logic [W-1:0] b);
        logic [2*W-1:0] ea, eb;
        ea = sgn ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
        eb = sgn ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
        return ea * eb;
    endfunction

    function automatic bit fit_model(input bit sgn, input logic [2*W-1:0] p);
        if (sgn) return p[2*W-1:W] == {W{p[W-1]}};
        return p[2*W-1:W] == '0;
    endfunction

    task automatic push(input logic [W-1:0] v, input string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endtask

    // Full multiply: busy length, fit status, then both halves read back.
    task automatic do_mul(input bit sgn, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [2*W-1:0] p;
        int n;
        p = model(sgn, a, b);
        issue(sgn ? 2'b00 : 2'b01, a, b);
        n = 1;
        while (busy) begin n++; @(negedge clk); end
        chk(n - 1 == W + 2, "R5 busy length", 64'(n - 1), 64'(W + 2));
        chk(fits_n == fit_model(sgn, p), sgn ? "R8 signed fit" : "R7 unsigned fit",
            64'(fits_n), 64'(fit_model(sgn, p)));
        push(p[2*W-1:W], sgn ? "R1 signed hi" : "R2 unsigned hi");
        issue(2'b10, '0, '0);
        push(p[W-1:0], sgn ? "R1 signed lo" : "R2 unsigned lo");
        issue(2'b11, '0, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [2*W-1:0] p1, p2;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R10: reset state at the ports.
        chk(busy == 1'b0, "R10 busy", 64'(busy), 64'(0));
        chk(rd_valid == 1'b0, "R10 rd_valid", 64'(rd_valid), 64'(0));
        chk(fits_n == 1'b1, "R10 fits_n", 64'(fits_n), 64'(1));
        push('0, "R10 hi reset"); issue(2'b10, '0, '0);
        push('0, "R10 lo reset"); issue(2'b11, '0, '0);

        // R1/R2/R7/R8 directed corners.
        do_mul(1'b1, 32'd7, 32'd3);
        do_mul(1'b1, -32'sd5, -32'sd3);
        do_mul(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        do_mul(1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        do_mul(1'b1, 32'h8000_0000, 32'h8000_0000);
        do_mul(1'b1, 32'h8000_0000, 32'd1);
        do_mul(1'b1, 32'h0001_0000, 32'hFFFF_8000);
        do_mul(1'b1, 32'h0001_0000, 32'h0000_8000);
        do_mul(1'b0, 32'h0001_0000, 32'h0000_FFFF);
        do_mul(1'b0, 32'h0001_0000, 32'h0001_0000);
        do_mul(1'b0, 32'd0, 32'hDEAD_BEEF);
        do_mul(1'b0, 32'h8000_0000, 32'd3);

        // R9: repeated reads leave the registers unchanged.
        p1 = model(1'b0, 32'h8000_0000, 32'd3);
        push(p1[2*W-1:W], "R9 hi after reads"); issue(2'b10, '0, '0);
        push(p1[W-1:0], "R9 lo after reads"); issue(2'b11, '0, '0);
        chk(fits_n == 1'b0, "R9 fits_n kept", 64'(fits_n), 64'(0));

        // R6: a read presented while busy returns the new result.
        p1 = model(1'b1, 32'h1234_5678, -32'sd9);
        issue(2'b00, 32'h1234_5678, -32'sd9);
        push(p1[2*W-1:W], "R6 held read hi");
        issue(2'b10, '0, '0);
        push(p1[W-1:0], "R6 held read lo");
        issue(2'b11, '0, '0);

        // R5: a multiply presented while busy waits and then replaces the result.
        p2 = model(1'b0, 32'hCAFE_0001, 32'h0000_0100);
        issue(2'b01, 32'h1111_1111, 32'h2222_2222);
        issue(2'b01, 32'hCAFE_0001, 32'h0000_0100);
        push(p2[2*W-1:W], "R5 held multiply hi");
        issue(2'b10, '0, '0);
        push(p2[W-1:0], "R5 held multiply lo");
        issue(2'b11, '0, '0);
        chk(fits_n == fit_model(1'b0, p2), "R7 held multiply fit",
            64'(fits_n), 64'(fit_model(1'b0, p2)));

        // Mixed random commands against the model.
        for (int i = 0; i < 40; i++) begin
            logic [W-1:0] ra, rb;
            ra = $urandom;
            rb = $urandom;
            if (i % 4 == 1) rb = rb >> 20;
            if (i % 4 == 3) ra = {{20{ra[11]}}, ra[11:0]};
            do_mul(i % 2 == 0, ra, rb);
        end

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R3/R4 missing reads", 64'(exp_q.size()), 64'(0));
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule